// File: doc/BRIEF.md
# Exponent-Mantissa Wake-Up Timer

This block generates periodic wake-up events for a low-power controller. The period is written in a floating-point style: an 8-bit mantissa M multiplied by two raised to a 5-bit exponent R, counted in clock cycles that stand in for the slow base tick. A five-bit exponent lets one short configuration word reach periods from a single cycle up to hundreds of billions of cycles without a wide compare register.

The period is loaded through a 16-bit configuration word. The word is offered on a valid/ready port that never applies back-pressure. The timer runs only while its enable bit in the power configuration byte is set. Each expiry produces a one-cycle pulse and sets a sticky status flag. The flag stays set until a status-read strobe clears it.

The exponent is realised as a prescaler tap on a free-running counter, which gives one tick every 2^R cycles. A mantissa counter then counts M of those ticks.

Top module: `wut_timer`

## Requirements
- R1: A word on `cmd_data` is a timer configuration only when bits 15:13 are all ones. Bits 12:8 then hold the exponent R and bits 7:0 hold the mantissa M. Any other word changes neither the settings nor the running count.
- R2: `cmd_ready` is always high. A word is taken on every rising edge at which `cmd_valid` is high, so the port never stalls.
- R3: `wake_pulse` is high for exactly one cycle after every N = M·2^R counting edges. After a configuration word is accepted, the first pulse is visible in the cycle that follows the N-th rising edge after the accepting edge, and further pulses repeat every N cycles.
- R4: With M = 0, no pulse is ever produced and the flag is never set.
- R5: Counting happens only while `power_cfg[1]` is 1. While that bit is 0, both counters are held at zero. When the bit returns to 1, the first pulse follows the N-th edge at which it is seen high. The other bits of `power_cfg` have no effect.
- R6: Accepting a configuration word while the timer is counting discards the partial count. The next pulse comes N edges after the new word.
- R7: `wake_flag` is set on the same edge as each pulse. It stays set until `status_clr` is sampled high, and it is low in the cycle after that edge.
- R8: If `status_clr` and an expiry fall on the same edge, the flag ends up set.
- R9: After reset, `wake_pulse` and `wake_flag` are 0 and R = M = 0, so no event occurs until a configuration word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Configuration word offered |
| cmd_ready | output | 1 | Word accepted (always high) |
| cmd_data | input | 16 | Configuration word |
| power_cfg | input | 8 | Power configuration byte; bit 1 enables the timer |
| status_clr | input | 1 | Status-read strobe that clears the flag |
| wake_pulse | output | 1 | One-cycle expiry pulse |
| wake_flag | output | 1 | Sticky expiry status |

## Verification
A wrong internal state shows up at the ports in one of two ways: a pulse arrives on the wrong cycle, or a pulse never arrives. The bench therefore times each pulse to the exact cycle. It also checks that no pulse appears anywhere inside the expected gap.

A prescaler or mantissa count that is not cleared on reload or disable moves the next pulse earlier. That error is visible within one period. A wrong exponent or mantissa field changes the gap length on the very first period. A flag that is set or cleared wrongly differs at the port one cycle after the strobe or the expiry.

// File: rtl/wut_pkg.sv
package wut_pkg;
  localparam int WUT_EXP_W  = 5;
  localparam int WUT_MAN_W  = 8;
  localparam int WUT_KEY_W  = 3;
  localparam int WUT_EN_BIT = 1;
endpackage

// File: rtl/wut_cmd_decode.sv
module wut_cmd_decode #(
  parameter int EXP_W = wut_pkg::WUT_EXP_W,
  parameter int MAN_W = wut_pkg::WUT_MAN_W,
  parameter int KEY_W = wut_pkg::WUT_KEY_W,
  localparam int CMD_W = KEY_W + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_data,
  output logic [EXP_W-1:0] cfg_exp,
  output logic [MAN_W-1:0] cfg_man,
  output logic             reload
);
  logic key_hit;
  assign key_hit = &cmd_data[CMD_W-1 -: KEY_W];
  assign reload  = cmd_valid && key_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_exp <= '0;
      cfg_man <= '0;
    end else if (reload) begin
      cfg_exp <= cmd_data[MAN_W +: EXP_W];
      cfg_man <= cmd_data[MAN_W-1:0];
    end
  end

  // R1: a word without the key leaves the settings untouched
  a_r1_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !key_hit) |=> ($stable(cfg_exp) && $stable(cfg_man)));
endmodule

// File: rtl/wut_prescaler.sv
module wut_prescaler #(
  parameter int EXP_W = wut_pkg::WUT_EXP_W,
  localparam int PRE_W = 1 << EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;

  assign mask = (PRE_W'(1) << exp_sel) - PRE_W'(1);
  assign tick = run && !clear && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (run)    cnt <= cnt + PRE_W'(1);
  end

  // R6: a restart leaves the prescaler at zero
  a_r6_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
endmodule

// File: rtl/wut_mant_counter.sv
module wut_mant_counter #(
  parameter int MAN_W = wut_pkg::WUT_MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [MAN_W-1:0] mant,
  output logic             expire
);
  logic [MAN_W-1:0] cnt;
  logic             last;

  assign last   = (cnt == mant - MAN_W'(1));
  assign expire = tick && (mant != '0) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (expire)     cnt <= '0;
    else if (tick && mant != '0) cnt <= cnt + MAN_W'(1);
  end

  // R4: zero mantissa never expires
  a_r4_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mant == '0) |-> !expire);
  // R3: the count stays below a nonzero mantissa
  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mant != '0 && !clear) |=> (mant == '0 || cnt < mant || $changed(mant)));
endmodule

// File: rtl/wut_timer.sv
module wut_timer #(
  parameter int EXP_W  = wut_pkg::WUT_EXP_W,
  parameter int MAN_W  = wut_pkg::WUT_MAN_W,
  parameter int KEY_W  = wut_pkg::WUT_KEY_W,
  parameter int EN_BIT = wut_pkg::WUT_EN_BIT,
  localparam int CMD_W = KEY_W + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic [7:0]       power_cfg,
  input  logic             status_clr,
  output logic             wake_pulse,
  output logic             wake_flag
);
  logic [EXP_W-1:0] cfg_exp;
  logic [MAN_W-1:0] cfg_man;
  logic             reload;
  logic             en;
  logic             restart;
  logic             tick;
  logic             expire;

  assign cmd_ready = 1'b1;
  assign en        = power_cfg[EN_BIT];
  assign restart   = reload || !en;

  wut_cmd_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W), .KEY_W(KEY_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cfg_exp(cfg_exp), .cfg_man(cfg_man), .reload(reload));

  wut_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(restart), .run(en),
    .exp_sel(cfg_exp), .tick(tick));

  wut_mant_counter #(.MAN_W(MAN_W)) u_man (
    .clk(clk), .rst_n(rst_n), .clear(restart), .tick(tick),
    .mant(cfg_man), .expire(expire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_pulse <= 1'b0;
      wake_flag  <= 1'b0;
    end else begin
      wake_pulse <= expire;
      if (expire)          wake_flag <= 1'b1;
      else if (status_clr) wake_flag <= 1'b0;
    end
  end

  a_r7_pulse_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> wake_flag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !status_clr) |=> wake_flag);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && expire) |=> wake_flag);
  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wake_pulse);
endmodule

// File: tb/wut_timer_test.sv
module wut_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [15:0] cmd_data = '0;
  logic [7:0] power_cfg = 8'h00;
  logic status_clr = 1'b0;
  logic wake_pulse, wake_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wut_timer uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .power_cfg(power_cfg),
    .status_clr(status_clr), .wake_pulse(wake_pulse), .wake_flag(wake_flag));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // at a negedge: offer word, return at negedge after accepting edge
  task automatic send(input logic [15:0] w);
    cmd_valid = 1'b1; cmd_data = w;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_data = '0;
  endtask

  // expects pulse only after edge n (1-based), over `len` edges
  task automatic watch(input string req, input int n, input int len);
    int bad = 0;
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      if (wake_pulse !== (j == n)) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: actual %0d misplaced cycles expected 0 (pulse at %0d)", req, bad, n);
    end
  endtask

  task automatic t_reset;
    chk("R9 pulse", wake_pulse, 1'b0);
    chk("R9 flag", wake_flag, 1'b0);
    chk("R2 ready", cmd_ready, 1'b1);
    power_cfg = 8'h02;
    watch("R9 unconfigured silent", 0, 40);
  endtask

  task automatic t_period(input int r, input int m);
    int n = m << r;
    send(16'hE000 | 16'(r << 8) | 16'(m));
    watch("R3 first period", n, n);
    watch("R3 second period", n, n);
    chk("R7 flag set", wake_flag, 1'b1);
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
  endtask

  task automatic t_zero;
    send(16'hE300);
    watch("R4 zero mantissa", 0, 120);
    chk("R4 flag", wake_flag, 1'b0);
  endtask

  task automatic t_enable;
    send(16'hE104);                 // N = 8
    power_cfg = 8'hFD;              // every bit except enable
    watch("R5 disabled / other bits", 0, 30);
    power_cfg = 8'h02;
    watch("R5 restart on enable", 8, 8);
  endtask

  task automatic t_reload;
    send(16'hE205);                 // N = 20
    repeat (10) @(negedge clk);
    send(16'hE205);
    watch("R6 reload restarts", 20, 20);
  endtask

  task automatic t_foreign;
    send(16'hE006);                 // N = 6
    repeat (2) @(negedge clk);      // edges 1..2
    send(16'hC0FF);                 // edge 3, not a timer word
    watch("R1 foreign ignored", 3, 3);
    watch("R1 settings kept", 6, 6);
  endtask

  task automatic t_flag;
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
    chk("R7 cleared", wake_flag, 1'b0);
    send(16'hE003);                 // N = 3
    watch("R3 short", 3, 3);
    repeat (2) @(negedge clk);
    chk("R7 sticky", wake_flag, 1'b1);
    status_clr = 1'b1;              // edge 3 after the last pulse = expiry
    @(negedge clk); status_clr = 1'b0;
    chk("R8 set beats clear", wake_pulse, 1'b1);
    chk("R8 flag kept", wake_flag, 1'b1);
    send(16'hE001);                 // N = 1
    watch("R3 every cycle", 1, 1);
    watch("R3 every cycle again", 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_period(0, 3);
    t_period(2, 5);
    t_period(4, 2);
    t_zero;
    t_enable;
    t_reload;
    t_foreign;
    t_flag;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule